// File: doc/BRIEF.md
# Byte-Wide Memory Transfer Engine

This block copies words between a slow external memory that is eight bits wide and the on-chip program or data memory. Software sets four write-only registers: the control word, the on-chip start address, the external offset and the word count. Writing a nonzero word count starts the transfer. The engine then walks the external space one byte at a time. It builds each on-chip word from one, two or three bytes, or splits each on-chip word into that many bytes. Every finished word costs the core exactly one memory cycle.

The external address is 22 bits wide. It is an 8-bit page on top of a 14-bit offset, so the space holds 256 pages of 16K bytes, and a run that passes the end of a page carries into the next page. Every byte access waits for the external bus to be free of core traffic. It then holds its strobe for a programmed number of wait states. When the last word is done the engine raises a one-cycle interrupt. If the context-reset control bit is set, the engine also holds the core for the whole transfer and pulses a restart-at-zero request at the end.

Reset loads boot values and starts a transfer at once: 32 program-memory words are loaded from external address 0 while the core is held.

Top module: `bdma_engine`

## Requirements
- R1: After reset the word count reads 32 and a transfer starts at once. The boot settings are: format 0, direction byte-to-internal, context-reset 1, wait count 15, page, offset and internal address 0. `core_hold` is high from reset until the end of the transfer.
- R2: Register select 0 is the control word. Its fields are bits 1:0 format, bit 2 direction (0 = external to on-chip, 1 = on-chip to external), bit 3 context-reset, bits 7:4 wait count and bits 15:8 page. Select 1 is the on-chip address (13:0), select 2 the external offset (13:0) and select 3 the word count (13:0). A count write of a nonzero value while idle starts a transfer. A count write of zero starts nothing.
- R3: While a transfer is in progress, every register write is ignored. The address sequence, the format, the direction and the number of words all stay as they were at the start.
- R4: Format 0 is a 24-bit program-memory word (`im_pm`=1) made from 3 bytes. Format 1 is a 16-bit data word made from 2 bytes. Format 2 is one byte in bits 15:8 and format 3 is one byte in bits 7:0; in both, the other bits are zero. Bytes go most significant first in both directions.
- R5: The byte address is {page, offset}. It rises by one per byte, and an offset wrap carries into the page.
- R6: Each byte strobe (`bm_rd` or `bm_wr`) stays high for wait+1 cycles, with address and write data stable. Read data is taken in the strobe's last cycle.
- R7: No byte strobe begins in the cycle after one in which `ext_busy` was high.
- R8: Each word makes exactly one on-chip access. `im_req` stays high until `im_gnt` and falls in the next cycle. The number of grants equals the word count.
- R9: The count decrements by one per finished word. When it reaches zero the transfer stops and `irq` pulses for one cycle, with the count reading zero.
- R10: With context-reset 1, `core_hold` is high for the whole transfer and `core_restart` pulses together with `irq`. With context-reset 0, both stay low.
- R11: Only `bm_rd` is used when the direction is 0, and only `bm_wr` when it is 1. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| count_o | output | 14 | Remaining word count |
| bm_addr | output | 22 | External byte address |
| bm_rd | output | 1 | External byte read strobe |
| bm_wr | output | 1 | External byte write strobe |
| bm_wdata | output | 8 | External byte write data |
| bm_rdata | input | 8 | External byte read data |
| ext_busy | input | 1 | Core owns the external bus this cycle |
| im_req | output | 1 | On-chip memory request |
| im_we | output | 1 | On-chip access is a write |
| im_pm | output | 1 | Access targets program memory |
| im_addr | output | 14 | On-chip word address |
| im_wdata | output | 24 | Word written on chip |
| im_rdata | input | 24 | Word read from chip, valid with grant |
| im_gnt | input | 1 | On-chip access granted this cycle |
| core_hold | output | 1 | Core held |
| core_restart | output | 1 | Pulse: restart core at address 0 |
| irq | output | 1 | Completion pulse |

## Verification
The hardest case to reach is the page carry combined with the packing order. A single word's bytes must straddle an offset wrap, and in one case the wrap is at the very top of the 22-bit space, so the bench places start offsets one or two bytes below a page end. The bench also holds `ext_busy` high across a transfer start to show that no strobe can begin. It stalls grants on a repeating pattern so that `im_req` must wait.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
    localparam int PAGE_W  = 8;
    localparam int OFF_W   = 14;
    localparam int EADDR_W = PAGE_W + OFF_W;
    localparam int CNT_W   = 14;
    localparam int IADDR_W = 14;
    localparam int WAIT_W  = 4;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 3 * BYTE_W;

    typedef enum logic [1:0] {
        FMT_PM24  = 2'd0,
        FMT_DM16  = 2'd1,
        FMT_DM8HI = 2'd2,
        FMT_DM8LO = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_IADDR = 2'd1,
        SEL_EOFF  = 2'd2,
        SEL_COUNT = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_ACC,
        ST_MEM
    } state_e;

    // control word low byte: wait[7:4] ctx[3] dir[2] fmt[1:0]
    typedef struct packed {
        logic [WAIT_W-1:0] wait_n;
        logic              ctx;
        logic              dir;
        fmt_e              fmt;
    } ctrl_t;

    // index of the last byte within one word
    function automatic logic [1:0] last_byte(input fmt_e f);
        case (f)
            FMT_PM24: return 2'd2;
            FMT_DM16: return 2'd1;
            default:  return 2'd0;
        endcase
    endfunction

    // assembled shift register -> on-chip word
    function automatic logic [WORD_W-1:0] pack_word(input fmt_e f, input logic [WORD_W-1:0] sh);
        case (f)
            FMT_PM24:  return sh;
            FMT_DM16:  return {8'h00, sh[15:0]};
            FMT_DM8HI: return {8'h00, sh[7:0], 8'h00};
            default:   return {16'h0000, sh[7:0]};
        endcase
    endfunction

    // on-chip word -> shift register with first byte on top
    function automatic logic [WORD_W-1:0] align_word(input fmt_e f, input logic [WORD_W-1:0] w);
        case (f)
            FMT_PM24:  return w;
            FMT_DM16:  return {w[15:0], 8'h00};
            FMT_DM8HI: return {w[15:8], 16'h0000};
            default:   return {w[7:0], 16'h0000};
        endcase
    endfunction
endpackage

// File: rtl/bdma_addr_gen.sv
module bdma_addr_gen #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 14,
    localparam int AW    = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_page,
    input  logic [PAGE_W-1:0] page_d,
    input  logic              ld_off,
    input  logic [OFF_W-1:0]  off_d,
    input  logic              inc,
    output logic [AW-1:0]     addr
);
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (inc) begin
            {page_q, off_q} <= {page_q, off_q} + AW'(1);
        end else begin
            if (ld_page) page_q <= page_d;
            if (ld_off)  off_q  <= off_d;
        end
    end

    assign addr = {page_q, off_q};
endmodule

// File: rtl/bdma_wait_timer.sv
module bdma_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] wait_n,
    output logic         active,
    output logic         last
);
    logic [W-1:0] cnt_q;
    logic         act_q;

    assign active = act_q;
    assign last   = act_q && (cnt_q == wait_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (last) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/bdma_engine.sv
module bdma_engine import bdma_pkg::*; #(
    parameter logic [CNT_W-1:0]  BOOT_WORDS = 14'd32,
    parameter logic [WAIT_W-1:0] BOOT_WAIT  = 4'd15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [15:0]        reg_wdata,
    output logic [CNT_W-1:0]   count_o,
    output logic [EADDR_W-1:0] bm_addr,
    output logic               bm_rd,
    output logic               bm_wr,
    output logic [BYTE_W-1:0]  bm_wdata,
    input  logic [BYTE_W-1:0]  bm_rdata,
    input  logic               ext_busy,
    output logic               im_req,
    output logic               im_we,
    output logic               im_pm,
    output logic [IADDR_W-1:0] im_addr,
    output logic [WORD_W-1:0]  im_wdata,
    input  logic [WORD_W-1:0]  im_rdata,
    input  logic               im_gnt,
    output logic               core_hold,
    output logic               core_restart,
    output logic               irq
);
    ctrl_t              ctrl_q;
    state_e             state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [IADDR_W-1:0] iaddr_q;
    logic [1:0]         bidx_q;
    logic [WORD_W-1:0]  sh_q;
    logic               irq_q;
    logic               restart_q;

    logic idle, wr_ok, tmr_start, tmr_active, tmr_last, word_end;

    assign idle      = (state_q == ST_IDLE);
    assign wr_ok     = reg_we && idle;
    assign tmr_start = (state_q == ST_ARB) && !ext_busy;
    assign word_end  = (bidx_q == last_byte(ctrl_q.fmt));

    bdma_addr_gen #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ld_page (wr_ok && (reg_sel == SEL_CTRL)),
        .page_d  (reg_wdata[15:8]),
        .ld_off  (wr_ok && (reg_sel == SEL_EOFF)),
        .off_d   (reg_wdata[OFF_W-1:0]),
        .inc     ((state_q == ST_ACC) && tmr_last),
        .addr    (bm_addr)
    );

    bdma_wait_timer #(.W(WAIT_W)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .wait_n (ctrl_q.wait_n),
        .active (tmr_active),
        .last   (tmr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '{wait_n: BOOT_WAIT, ctx: 1'b1, dir: 1'b0, fmt: FMT_PM24};
            state_q   <= ST_ARB;
            cnt_q     <= BOOT_WORDS;
            iaddr_q   <= '0;
            bidx_q    <= '0;
            sh_q      <= '0;
            irq_q     <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            irq_q     <= 1'b0;
            restart_q <= 1'b0;
            if (wr_ok) begin
                case (sel_e'(reg_sel))
                    SEL_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata[7:0]);
                    SEL_IADDR: iaddr_q <= reg_wdata[IADDR_W-1:0];
                    SEL_EOFF:  ;
                    SEL_COUNT: begin
                        cnt_q  <= reg_wdata[CNT_W-1:0];
                        bidx_q <= '0;
                        if (reg_wdata[CNT_W-1:0] != '0)
                            state_q <= ctrl_q.dir ? ST_MEM : ST_ARB;
                    end
                    default: ;
                endcase
            end
            case (state_q)
                ST_ARB: if (!ext_busy) state_q <= ST_ACC;
                ST_ACC: if (tmr_last) begin
                    sh_q <= {sh_q[WORD_W-BYTE_W-1:0], ctrl_q.dir ? 8'h00 : bm_rdata};
                    if (!word_end) begin
                        bidx_q  <= bidx_q + 2'd1;
                        state_q <= ST_ARB;
                    end else begin
                        bidx_q <= '0;
                        if (!ctrl_q.dir) begin
                            state_q <= ST_MEM;
                        end else begin
                            cnt_q <= cnt_q - CNT_W'(1);
                            if (cnt_q == CNT_W'(1)) begin
                                state_q   <= ST_IDLE;
                                irq_q     <= 1'b1;
                                restart_q <= ctrl_q.ctx;
                            end else begin
                                state_q <= ST_MEM;
                            end
                        end
                    end
                end
                ST_MEM: if (im_gnt) begin
                    iaddr_q <= iaddr_q + IADDR_W'(1);
                    if (ctrl_q.dir) begin
                        sh_q    <= align_word(ctrl_q.fmt, im_rdata);
                        state_q <= ST_ARB;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(1)) begin
                            state_q   <= ST_IDLE;
                            irq_q     <= 1'b1;
                            restart_q <= ctrl_q.ctx;
                        end else begin
                            state_q <= ST_ARB;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign count_o      = cnt_q;
    assign bm_rd        = tmr_active && !ctrl_q.dir;
    assign bm_wr        = tmr_active && ctrl_q.dir;
    assign bm_wdata     = sh_q[WORD_W-1 -: BYTE_W];
    assign im_req       = (state_q == ST_MEM);
    assign im_we        = !ctrl_q.dir;
    assign im_pm        = (ctrl_q.fmt == FMT_PM24);
    assign im_addr      = iaddr_q;
    assign im_wdata     = pack_word(ctrl_q.fmt, sh_q);
    assign core_hold    = !idle && ctrl_q.ctx;
    assign core_restart = restart_q;
    assign irq          = irq_q;
endmodule

// File: rtl/bdma_engine_chk.sv
module bdma_engine_chk import bdma_pkg::*; (
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic               bm_rd,
    input logic               bm_wr,
    input logic               ext_busy,
    input logic               im_req,
    input logic               im_gnt,
    input logic               irq,
    input logic               core_restart,
    input logic [CNT_W-1:0]   count_o,
    input logic [BYTE_W-1:0]  bm_wdata,
    input logic [EADDR_W-1:0] bm_addr
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(bm_rd && bm_wr));

    // R7
    ext_prio_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bm_rd || bm_wr) |-> !$past(ext_busy));

    // R8
    one_steal_chk: assert property (@(posedge clk) disable iff (rst)
        (im_req && im_gnt) |=> !im_req);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);

    // R9
    irq_zero_chk: assert property (@(posedge clk) disable iff (rst) irq |-> (count_o == '0));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(count_o) && !$past(reg_we)) |-> (count_o == $past(count_o) - CNT_W'(1)));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst) core_restart |-> irq);

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((bm_rd || bm_wr) && $past(bm_rd || bm_wr)) |-> ($stable(bm_addr) && $stable(bm_wdata)));
endmodule

bind bdma_engine bdma_engine_chk u_chk (.*);

// File: tb/bdma_engine_bench.sv
`timescale 1ns/1ps
module bdma_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [13:0] count_o;
    logic [21:0] bm_addr;
    logic        bm_rd, bm_wr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic        ext_busy = 1'b0;
    logic        im_req, im_we, im_pm;
    logic [13:0] im_addr;
    logic [23:0] im_wdata, im_rdata;
    logic        im_gnt;
    logic        gnt_ok = 1'b1;
    logic [2:0]  gcnt = 3'd0;
    logic        core_hold, core_restart, irq;

    always #2 clk = ~clk;

    bdma_engine u_bdma_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .count_o(count_o), .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .ext_busy(ext_busy),
        .im_req(im_req), .im_we(im_we), .im_pm(im_pm), .im_addr(im_addr),
        .im_wdata(im_wdata), .im_rdata(im_rdata), .im_gnt(im_gnt),
        .core_hold(core_hold), .core_restart(core_restart), .irq(irq)
    );

    function automatic logic [7:0] ebyte(input logic [21:0] a);
        return a[7:0] ^ a[21:14] ^ 8'h3C;
    endfunction
    function automatic logic [23:0] iword(input logic [13:0] a);
        logic [7:0] i;
        i = a[7:0];
        return {i ^ 8'hC3, i + 8'h51, i ^ 8'h96};
    endfunction
    function automatic int nbytes(input logic [1:0] f);
        return (f == 2'd0) ? 3 : (f == 2'd1) ? 2 : 1;
    endfunction
    function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [21:0] a);
        logic [7:0] b0, b1, b2;
        b0 = ebyte(a); b1 = ebyte(a + 22'd1); b2 = ebyte(a + 22'd2);
        case (f)
            2'd0: return {b0, b1, b2};
            2'd1: return {8'h00, b0, b1};
            2'd2: return {8'h00, b0, 8'h00};
            default: return {16'h0000, b0};
        endcase
    endfunction
    function automatic logic [7:0] exp_byte(input logic [1:0] f, input logic [23:0] w, input int j);
        case (f)
            2'd0: return (j == 0) ? w[23:16] : (j == 1) ? w[15:8] : w[7:0];
            2'd1: return (j == 0) ? w[15:8] : w[7:0];
            2'd2: return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    assign bm_rdata = ebyte(bm_addr);
    assign im_rdata = iword(im_addr);
    assign im_gnt   = im_req && gnt_ok;

    always @(posedge clk) begin
        gcnt   <= gcnt + 3'd1;
        gnt_ok <= (gcnt != 3'd1) && (gcnt != 3'd4);
    end

    // settings of the current transfer, driven by the main flow
    logic [1:0] cur_fmt = 2'd0;
    logic       cur_dir = 1'b0;
    logic       cur_ctx = 1'b1;
    logic [3:0] cur_wait = 4'd15;
    logic       in_xfer = 1'b1;
    int         xfer_irq_base = 0;

    // monitor state, driven only here
    int run = 0, strobes = 0, grants = 0, irq_n = 0, restart_n = 0;
    int strobe_err = 0, prio_err = 0, pm_err = 0, dir_err = 0, hold_err = 0;
    logic prev_busy = 1'b0;
    logic [13:0] wlog_a [256];
    logic [23:0] wlog_d [256];
    int wn = 0;
    logic [21:0] blog_a [256];
    logic [7:0]  blog_d [256];
    int bn = 0;

    always @(negedge clk) begin
        if (bm_rd || bm_wr) begin
            run = run + 1;
            if (bm_rd == cur_dir || bm_wr != cur_dir) dir_err = dir_err + 1;
            if (run == 1) begin
                strobes = strobes + 1;
                if (prev_busy) prio_err = prio_err + 1;
                if (bm_wr && bn < 256) begin
                    blog_a[bn] = bm_addr; blog_d[bn] = bm_wdata; bn = bn + 1;
                end
            end
        end else if (run != 0) begin
            if (run != int'(cur_wait) + 1) strobe_err = strobe_err + 1;
            run = 0;
        end
        if (im_req && im_gnt) begin
            grants = grants + 1;
            if (im_pm != (cur_fmt == 2'd0)) pm_err = pm_err + 1;
            if (im_we && wn < 256) begin
                wlog_a[wn] = im_addr; wlog_d[wn] = im_wdata; wn = wn + 1;
            end
        end
        if (irq) irq_n = irq_n + 1;
        if (core_restart) restart_n = restart_n + 1;
        if (in_xfer && !irq && irq_n == xfer_irq_base && core_hold != cur_ctx) hold_err = hold_err + 1;
        prev_busy = ext_busy;
    end

    int checks = 0, fails = 0;
    logic done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic wait_irq(input int base, input int lim);
        int t;
        t = 0;
        while (irq_n == base && t < lim) begin
            @(negedge clk); t++;
        end
        chk(irq_n != base, "R9", "irq before timeout", irq_n, base + 1);
        in_xfer = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  fmt;
        logic        dir;
        logic        ctx;
        logic [3:0]  wt;
        logic [7:0]  page;
        logic [13:0] off;
        logic [13:0] ia;
        logic [13:0] cnt;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{fmt:2'd0, dir:1'b0, ctx:1'b0, wt:4'd2, page:8'h03, off:14'h0010, ia:14'd4,  cnt:14'd3},
        '{fmt:2'd1, dir:1'b0, ctx:1'b1, wt:4'd0, page:8'h05, off:14'h3FFE, ia:14'd8,  cnt:14'd4},
        '{fmt:2'd2, dir:1'b0, ctx:1'b0, wt:4'd1, page:8'h10, off:14'h0100, ia:14'd20, cnt:14'd3},
        '{fmt:2'd3, dir:1'b0, ctx:1'b0, wt:4'd3, page:8'hFF, off:14'h3FFF, ia:14'd30, cnt:14'd2},
        '{fmt:2'd0, dir:1'b1, ctx:1'b1, wt:4'd1, page:8'h02, off:14'h3FFF, ia:14'd10, cnt:14'd2},
        '{fmt:2'd1, dir:1'b1, ctx:1'b0, wt:4'd0, page:8'h07, off:14'h0005, ia:14'd40, cnt:14'd3},
        '{fmt:2'd2, dir:1'b1, ctx:1'b0, wt:4'd2, page:8'h01, off:14'h0000, ia:14'd50, cnt:14'd2},
        '{fmt:2'd3, dir:1'b1, ctx:1'b0, wt:4'd0, page:8'h09, off:14'h0009, ia:14'd60, cnt:14'd3}
    };

    task automatic setup(input vec_t v);
        cur_fmt = v.fmt; cur_dir = v.dir; cur_ctx = v.ctx; cur_wait = v.wt;
        wr(2'd0, {v.page, v.wt, v.ctx, v.dir, v.fmt});
        wr(2'd1, {2'b00, v.ia});
        wr(2'd2, {2'b00, v.off});
    endtask

    task automatic check_load(input vec_t v, input int wbase, input string req);
        logic [21:0] a;
        chk(wn - wbase == int'(v.cnt), req, "words written", wn - wbase, v.cnt);
        a = {v.page, v.off};
        for (int k = 0; k < int'(v.cnt) && wbase + k < wn; k++) begin
            chk(wlog_a[wbase+k] == v.ia + 14'(k), req, "word address", wlog_a[wbase+k], v.ia + 14'(k));
            chk(wlog_d[wbase+k] == exp_word(v.fmt, a), req, "word data (R4 R5)",
                wlog_d[wbase+k], exp_word(v.fmt, a));
            a = a + 22'(nbytes(v.fmt));
        end
    endtask

    task automatic run_vec(input vec_t v);
        int b_irq, b_gr, b_rs, b_st, b_pm, b_dr, b_hd, b_wn, b_bn;
        logic [21:0] a;
        setup(v);
        b_irq = irq_n; b_gr = grants; b_rs = restart_n; b_st = strobe_err;
        b_pm = pm_err; b_dr = dir_err; b_hd = hold_err; b_wn = wn; b_bn = bn;
        xfer_irq_base = irq_n;
        wr(2'd3, {2'b00, v.cnt});
        in_xfer = 1'b1;
        wait_irq(b_irq, 5000);
        chk(irq_n - b_irq == 1, "R9", "single irq pulse", irq_n - b_irq, 1);
        chk(count_o == 14'd0, "R9", "count at end", count_o, 0);
        chk(grants - b_gr == int'(v.cnt), "R8", "stolen cycles", grants - b_gr, v.cnt);
        chk(restart_n - b_rs == int'(v.ctx), "R10", "restart pulses", restart_n - b_rs, v.ctx);
        chk(hold_err == b_hd, "R10", "core_hold level", hold_err - b_hd, 0);
        chk(strobe_err == b_st, "R6", "strobe length", strobe_err - b_st, 0);
        chk(pm_err == b_pm, "R4", "program memory select", pm_err - b_pm, 0);
        chk(dir_err == b_dr, "R11", "strobe direction", dir_err - b_dr, 0);
        if (!v.dir) begin
            check_load(v, b_wn, "R4");
        end else begin
            chk(bn - b_bn == int'(v.cnt) * nbytes(v.fmt), "R4", "bytes written",
                bn - b_bn, int'(v.cnt) * nbytes(v.fmt));
            a = {v.page, v.off};
            for (int k = 0; k < int'(v.cnt); k++) begin
                for (int j = 0; j < nbytes(v.fmt); j++) begin
                    int idx;
                    idx = b_bn + k * nbytes(v.fmt) + j;
                    if (idx < bn) begin
                        chk(blog_a[idx] == a, "R5", "byte address", blog_a[idx], a);
                        chk(blog_d[idx] == exp_byte(v.fmt, iword(v.ia + 14'(k)), j), "R4",
                            "byte data", blog_d[idx], exp_byte(v.fmt, iword(v.ia + 14'(k)), j));
                    end
                    a = a + 22'd1;
                end
            end
        end
    endtask

    initial begin
        vec_t boot_v, v;
        int b_irq, b_st;
        // R1: reset state and boot transfer
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(count_o == 14'd32, "R1", "boot count", count_o, 32);
        chk(core_hold == 1'b1, "R1", "core held at boot", core_hold, 1);
        chk(irq == 1'b0, "R1", "no irq at reset", irq, 0);
        boot_v = '{fmt:2'd0, dir:1'b0, ctx:1'b1, wt:4'd15, page:8'h00, off:14'h0000, ia:14'd0, cnt:14'd32};
        wait_irq(0, 8000);
        chk(restart_n == 1, "R1", "boot restart pulse", restart_n, 1);
        chk(strobe_err == 0, "R1", "boot wait count 15", strobe_err, 0);
        chk(hold_err == 0, "R10", "hold through boot", hold_err, 0);
        check_load(boot_v, 0, "R1");

        // table of transfers
        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R2: zero count starts nothing
        v = '{fmt:2'd3, dir:1'b0, ctx:1'b0, wt:4'd0, page:8'h00, off:14'h0000, ia:14'd0, cnt:14'd0};
        setup(v);
        b_irq = irq_n; b_st = strobes;
        wr(2'd3, 16'h0000);
        repeat (40) @(negedge clk);
        chk(strobes == b_st, "R2", "no strobe after zero count", strobes - b_st, 0);
        chk(irq_n == b_irq, "R2", "no irq after zero count", irq_n - b_irq, 0);
        chk(count_o == 14'd0, "R2", "count stays zero", count_o, 0);

        // R3: writes during a transfer are ignored
        v = '{fmt:2'd3, dir:1'b0, ctx:1'b0, wt:4'd3, page:8'h04, off:14'h0020, ia:14'd5, cnt:14'd4};
        setup(v);
        b_irq = irq_n; b_st = wn;
        xfer_irq_base = irq_n;
        wr(2'd3, {2'b00, v.cnt});
        in_xfer = 1'b1;
        repeat (6) @(posedge clk);
        wr(2'd2, 16'h1000);
        wr(2'd3, 16'd100);
        wr(2'd0, 16'hFF07);
        wr(2'd1, 16'd33);
        chk(count_o <= 14'd4, "R3", "count not reloaded", count_o, 4);
        wait_irq(b_irq, 3000);
        check_load(v, b_st, "R3");

        // R7: external bus priority holds off byte strobes
        v = '{fmt:2'd3, dir:1'b0, ctx:1'b0, wt:4'd0, page:8'h00, off:14'h0040, ia:14'd2, cnt:14'd1};
        setup(v);
        @(posedge clk); #1 ext_busy = 1'b1;
        b_irq = irq_n; b_st = strobes;
        xfer_irq_base = irq_n;
        wr(2'd3, 16'd1);
        in_xfer = 1'b1;
        repeat (30) @(negedge clk);
        chk(strobes == b_st, "R7", "no strobe while bus busy", strobes - b_st, 0);
        @(posedge clk); #1 ext_busy = 1'b0;
        b_st = wn;
        wait_irq(b_irq, 500);
        check_load(v, b_st, "R7");
        chk(prio_err == 0, "R7", "strobe after busy cycle", prio_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end
endmodule